// File: doc/BRIEF.md
# Secured Subcommand Sequencer

This block sits behind a host register interface and turns 16-bit subcommand words into single-cycle action pulses for the rest of the chip. It keeps a three-valued security level and refuses the privileged subcommands while the level is sealed. When it refuses a word, it raises a reject pulse in place of the action.

Critical actions need a confirmation before they fire. Deep sleep and shutdown each need the same word written twice in a row. The permanent-fail force needs a two-word sequence: an arming word followed directly by a firing word. Either confirmation must arrive before a timer, advanced by a free-running tick input, runs out. Any other write in between cancels the pending confirmation. A shutdown confirmed while the level is not sealed also raises a fast-shutdown flag, which tells the power sequencer to skip its delays.

A level-raise request input moves the block from sealed to unsealed. It stands for the outcome of a key check made elsewhere. A second request input moves the block from unsealed to full access.

Top module: `subcmd_guard`

## Requirements
- R1: After reset, `sec_level` reads sealed and every action and reject output is low. The level encoding is 2'b10 for sealed, 2'b01 for unsealed and 2'b00 for full access.
- R2: Word 0x000F fires `act_deepsleep` only when it is written twice in a row with the second write inside the window. The first write of the pair produces no pulse.
- R3: Word 0x0010 written twice in a row inside the window fires `act_shutdown`. If the level is not sealed when the second write arrives, `act_fast_shutdown` is raised in the same cycle. If the level is sealed, `act_fast_shutdown` stays low.
- R4: Word 0x2857 followed directly by word 0x29A3, inside the window, fires `act_pf_force` on the 0x29A3 write.
- R5: A 0x29A3 write that does not directly follow a live 0x2857 produces no output at all.
- R6: While the level is sealed, the following words raise `cmd_reject` and no action, and the level stays sealed: 0x0012, 0x001C to 0x0020 inclusive, 0x0022, 0x0024, 0x0030, 0x0090, 0x29BC, 0x29E7 and 0x7C40.
- R7: `unseal_req` moves the level from sealed to unsealed, and `full_access_req` moves it from unsealed to full access. In any other level each request has no effect. An accepted 0x0030 write fires `act_seal` and sets the level to sealed.
- R8: The window closes on the WINDOW_TICKS-th tick counted after the arming write. A tick in the same cycle as the arming write is not counted. A confirming write is accepted only while the window is still open.
- R9: Any write other than the expected confirming word cancels a pending pair, including a write that is rejected. A repeated first word that is not a valid confirmation re-arms the pair and restarts the window.
- R10: Word 0x0092 fires `act_cfg_exit` at every level. The same pulse also tells the status logic to clear its power-on and watchdog flags. When the level is not sealed, 0x0090 fires `act_cfg_enter` and 0x0012 fires `act_reset`.
- R11: Every action and reject output is a one-cycle pulse, registered on the clock edge that samples the write. At most one of them is high in any cycle; the only exception is `act_fast_shutdown`, which is always paired with `act_shutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 16 | Subcommand word |
| cmd_wr | input | 1 | Write strobe; one cycle per word |
| tick | input | 1 | Window timebase pulse |
| unseal_req | input | 1 | Raise level from sealed to unsealed |
| full_access_req | input | 1 | Raise level from unsealed to full access |
| act_deepsleep | output | 1 | Deep-sleep entry pulse |
| act_shutdown | output | 1 | Shutdown start pulse |
| act_fast_shutdown | output | 1 | Shutdown with delays skipped |
| act_reset | output | 1 | Device reset pulse |
| act_seal | output | 1 | Seal pulse |
| act_pf_force | output | 1 | Permanent-fail force pulse |
| act_cfg_enter | output | 1 | Configuration-update entry pulse |
| act_cfg_exit | output | 1 | Configuration-update exit and status-clear pulse |
| cmd_reject | output | 1 | Privileged word refused |
| sec_level | output | 2 | Current security level |

## Verification
Every pulse and every level change appears exactly one clock edge after the edge that samples the write or request: there is a single register stage between input and output. The bench drives each input on a falling edge and removes it on the next falling edge. It then reads all outputs at that same falling edge, which is half a period after the edge that registered them and inside the only cycle in which the pulse is high. Window tests count whole tick cycles between the two writes, so that each tests one exact side of the WINDOW_TICKS boundary.

// File: rtl/subcmd_pkg.sv
package subcmd_pkg;

    typedef enum logic [1:0] {
        LVL_FULL     = 2'b00,
        LVL_UNSEALED = 2'b01,
        LVL_SEALED   = 2'b10
    } sec_level_e;

    typedef enum logic [3:0] {
        CL_NONE,
        CL_DEEPSLEEP,
        CL_SHUTDOWN,
        CL_RESET,
        CL_SEAL,
        CL_CFG_ENTER,
        CL_CFG_EXIT,
        CL_PF_ARM,
        CL_PF_FIRE,
        CL_GUARDED
    } cmd_class_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_DEEPSLEEP,
        PEND_SHUTDOWN,
        PEND_PF
    } pend_e;

    typedef struct packed {
        logic deepsleep;
        logic shutdown;
        logic fast_shutdown;
        logic reset;
        logic seal;
        logic pf_force;
        logic cfg_enter;
        logic cfg_exit;
        logic reject;
    } pulse_t;

    localparam logic [15:0] W_DEEPSLEEP  = 16'h000F;
    localparam logic [15:0] W_SHUTDOWN   = 16'h0010;
    localparam logic [15:0] W_RESET      = 16'h0012;
    localparam logic [15:0] W_FETT_LO    = 16'h001C;
    localparam logic [15:0] W_FETT_HI    = 16'h0020;
    localparam logic [15:0] W_SEAL       = 16'h0030;
    localparam logic [15:0] W_CFG_ENTER  = 16'h0090;
    localparam logic [15:0] W_CFG_EXIT   = 16'h0092;
    localparam logic [15:0] W_PF_ARM     = 16'h2857;
    localparam logic [15:0] W_PF_FIRE    = 16'h29A3;

    localparam int N_GUARD_XTRA = 5;
    localparam logic [15:0] GUARD_XTRA [N_GUARD_XTRA] = '{
        16'h0022, 16'h0024, 16'h29BC, 16'h29E7, 16'h7C40
    };

endpackage

// File: rtl/subcmd_classify.sv
module subcmd_classify
    import subcmd_pkg::*;
(
    input  logic [15:0] word_i,
    output cmd_class_e  class_o,
    output logic        privileged_o
);

    logic xtra_hit;

    always_comb begin
        xtra_hit = 1'b0;
        for (int i = 0; i < N_GUARD_XTRA; i++) begin
            if (word_i == GUARD_XTRA[i]) xtra_hit = 1'b1;
        end
    end

    always_comb begin
        class_o = CL_NONE;
        unique case (word_i)
            W_DEEPSLEEP: class_o = CL_DEEPSLEEP;
            W_SHUTDOWN:  class_o = CL_SHUTDOWN;
            W_RESET:     class_o = CL_RESET;
            W_SEAL:      class_o = CL_SEAL;
            W_CFG_ENTER: class_o = CL_CFG_ENTER;
            W_CFG_EXIT:  class_o = CL_CFG_EXIT;
            W_PF_ARM:    class_o = CL_PF_ARM;
            W_PF_FIRE:   class_o = CL_PF_FIRE;
            default: begin
                if (xtra_hit || (word_i >= W_FETT_LO && word_i <= W_FETT_HI))
                    class_o = CL_GUARDED;
            end
        endcase
    end

    always_comb begin
        privileged_o = (class_o == CL_RESET) || (class_o == CL_SEAL) ||
                       (class_o == CL_CFG_ENTER) || (class_o == CL_GUARDED);
    end

endmodule

// File: rtl/subcmd_window.sv
module subcmd_window #(
    parameter int WINDOW_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic cancel_i,
    input  logic tick_i,
    output logic open_o
);

    localparam int CNT_W = (WINDOW_TICKS < 2) ? 1 : $clog2(WINDOW_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (arm_i) begin
            win_d.open = 1'b1;
            win_d.cnt  = '0;
        end else if (cancel_i) begin
            win_d.open = 1'b0;
            win_d.cnt  = '0;
        end else if (win_q.open && tick_i) begin
            if (win_q.cnt == LAST) begin
                win_d.open = 1'b0;
                win_d.cnt  = '0;
            end else begin
                win_d.cnt = win_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign open_o = win_q.open;

    // R8: the last counted tick closes the window
    p_window_expires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.open && tick_i && !arm_i && !cancel_i && win_q.cnt == LAST) |=> !win_q.open);

    // R8: arming always opens a fresh window
    p_arm_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (win_q.open && win_q.cnt == '0));

    // R9: a cancel without a re-arm closes the window
    p_cancel_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && !arm_i) |=> !win_q.open);

endmodule

// File: rtl/subcmd_guard.sv
module subcmd_guard
    import subcmd_pkg::*;
#(
    parameter int WINDOW_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cmd_word,
    input  logic        cmd_wr,
    input  logic        tick,
    input  logic        unseal_req,
    input  logic        full_access_req,
    output logic        act_deepsleep,
    output logic        act_shutdown,
    output logic        act_fast_shutdown,
    output logic        act_reset,
    output logic        act_seal,
    output logic        act_pf_force,
    output logic        act_cfg_enter,
    output logic        act_cfg_exit,
    output logic        cmd_reject,
    output logic [1:0]  sec_level
);

    typedef struct packed {
        sec_level_e level;
        pend_e      pend;
        pulse_t     pulse;
    } guard_t;

    guard_t     st_d, st_q;
    cmd_class_e cls;
    logic       privileged;
    logic       win_open;
    logic       arm, cancel;
    logic       blocked, confirm;

    subcmd_classify u_classify (
        .word_i       (cmd_word),
        .class_o      (cls),
        .privileged_o (privileged)
    );

    subcmd_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .cancel_i (cancel),
        .tick_i   (tick),
        .open_o   (win_open)
    );

    always_comb begin
        blocked = privileged && (st_q.level == LVL_SEALED);
        confirm = win_open && (
                  (st_q.pend == PEND_DEEPSLEEP && cls == CL_DEEPSLEEP) ||
                  (st_q.pend == PEND_SHUTDOWN  && cls == CL_SHUTDOWN)  ||
                  (st_q.pend == PEND_PF        && cls == CL_PF_FIRE));
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        arm        = 1'b0;
        cancel     = 1'b0;

        if (cmd_wr) begin
            if (blocked) begin
                st_d.pulse.reject = 1'b1;
                st_d.pend         = PEND_NONE;
                cancel            = 1'b1;
            end else if (confirm) begin
                st_d.pend = PEND_NONE;
                cancel    = 1'b1;
                unique case (st_q.pend)
                    PEND_DEEPSLEEP: st_d.pulse.deepsleep = 1'b1;
                    PEND_SHUTDOWN: begin
                        st_d.pulse.shutdown      = 1'b1;
                        st_d.pulse.fast_shutdown = (st_q.level != LVL_SEALED);
                    end
                    PEND_PF:        st_d.pulse.pf_force = 1'b1;
                    default: ;
                endcase
            end else begin
                st_d.pend = PEND_NONE;
                cancel    = 1'b1;
                unique case (cls)
                    CL_DEEPSLEEP: begin
                        st_d.pend = PEND_DEEPSLEEP;
                        arm       = 1'b1;
                    end
                    CL_SHUTDOWN: begin
                        st_d.pend = PEND_SHUTDOWN;
                        arm       = 1'b1;
                    end
                    CL_PF_ARM: begin
                        st_d.pend = PEND_PF;
                        arm       = 1'b1;
                    end
                    CL_RESET:     st_d.pulse.reset     = 1'b1;
                    CL_CFG_ENTER: st_d.pulse.cfg_enter = 1'b1;
                    CL_CFG_EXIT:  st_d.pulse.cfg_exit  = 1'b1;
                    CL_SEAL: begin
                        st_d.pulse.seal = 1'b1;
                        st_d.level      = LVL_SEALED;
                    end
                    default: ;
                endcase
                if (arm) cancel = 1'b0;
            end
        end

        if (!st_d.pulse.seal) begin
            if (unseal_req && st_q.level == LVL_SEALED)
                st_d.level = LVL_UNSEALED;
            else if (full_access_req && st_q.level == LVL_UNSEALED)
                st_d.level = LVL_FULL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= LVL_SEALED;
            st_q.pend  <= PEND_NONE;
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_deepsleep     = st_q.pulse.deepsleep;
    assign act_shutdown      = st_q.pulse.shutdown;
    assign act_fast_shutdown = st_q.pulse.fast_shutdown;
    assign act_reset         = st_q.pulse.reset;
    assign act_seal          = st_q.pulse.seal;
    assign act_pf_force      = st_q.pulse.pf_force;
    assign act_cfg_enter     = st_q.pulse.cfg_enter;
    assign act_cfg_exit      = st_q.pulse.cfg_exit;
    assign cmd_reject        = st_q.pulse.reject;
    assign sec_level         = st_q.level;

    // R11: at most one action or reject per cycle
    p_single_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_deepsleep, act_shutdown, act_reset, act_seal,
                  act_pf_force, act_cfg_enter, act_cfg_exit, cmd_reject}));

    // R11: every pulse stems from a write on the previous edge
    p_pulse_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_deepsleep || act_shutdown || act_reset || act_seal || act_pf_force ||
         act_cfg_enter || act_cfg_exit || cmd_reject) |-> $past(cmd_wr));

    // R3: fast shutdown only with shutdown, and only from a raised level
    p_fast_with_shutdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_fast_shutdown |-> (act_shutdown && $past(sec_level) != LVL_SEALED));

    // R6: rejects happen only while sealed
    p_reject_when_sealed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> ($past(sec_level) == LVL_SEALED && sec_level == LVL_SEALED));

    // R7: seal lands in the sealed level
    p_seal_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_seal |-> (sec_level == LVL_SEALED));

    // R4: PF force follows a firing word
    p_pf_on_fire_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_pf_force |-> ($past(cmd_wr) && $past(cmd_word) == W_PF_FIRE));

    // R2: deep sleep follows its own word
    p_ds_on_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_deepsleep |-> ($past(cmd_wr) && $past(cmd_word) == W_DEEPSLEEP));

endmodule

// File: tb/subcmd_guard_tb.sv
module subcmd_guard_tb;

    localparam int WT = 4;

    localparam logic [8:0] P_DS   = 9'h100;
    localparam logic [8:0] P_SH   = 9'h080;
    localparam logic [8:0] P_FAST = 9'h040;
    localparam logic [8:0] P_RST  = 9'h020;
    localparam logic [8:0] P_SEAL = 9'h010;
    localparam logic [8:0] P_PF   = 9'h008;
    localparam logic [8:0] P_CE   = 9'h004;
    localparam logic [8:0] P_CX   = 9'h002;
    localparam logic [8:0] P_REJ  = 9'h001;

    localparam logic [1:0] L_SEALED = 2'b10;
    localparam logic [1:0] L_UNSEAL = 2'b01;
    localparam logic [1:0] L_FULL   = 2'b00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_wr = 1'b0;
    logic        tick = 1'b0;
    logic        unseal_req = 1'b0;
    logic        full_access_req = 1'b0;
    logic        act_deepsleep, act_shutdown, act_fast_shutdown, act_reset;
    logic        act_seal, act_pf_force, act_cfg_enter, act_cfg_exit, cmd_reject;
    logic [1:0]  sec_level;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] snap;
    logic [1:0] lvl_snap;

    always #5 clk = ~clk;

    subcmd_guard #(.WINDOW_TICKS(WT)) u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_word (cmd_word), .cmd_wr (cmd_wr),
        .tick (tick), .unseal_req (unseal_req), .full_access_req (full_access_req),
        .act_deepsleep (act_deepsleep), .act_shutdown (act_shutdown),
        .act_fast_shutdown (act_fast_shutdown), .act_reset (act_reset),
        .act_seal (act_seal), .act_pf_force (act_pf_force),
        .act_cfg_enter (act_cfg_enter), .act_cfg_exit (act_cfg_exit),
        .cmd_reject (cmd_reject), .sec_level (sec_level)
    );

    function automatic logic [8:0] outs();
        return {act_deepsleep, act_shutdown, act_fast_shutdown, act_reset,
                act_seal, act_pf_force, act_cfg_enter, act_cfg_exit, cmd_reject};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        cmd_word = w;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
        snap     = outs();
        lvl_snap = sec_level;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic req_unseal();
        @(negedge clk);
        unseal_req = 1'b1;
        @(negedge clk);
        unseal_req = 1'b0;
        lvl_snap = sec_level;
        snap     = outs();
    endtask

    task automatic req_full();
        @(negedge clk);
        full_access_req = 1'b1;
        @(negedge clk);
        full_access_req = 1'b0;
        lvl_snap = sec_level;
        snap     = outs();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 level", 32'(sec_level), 32'(L_SEALED));
        chk("R1 pulses", 32'(outs()), 32'h0);
    endtask

    task automatic t_deepsleep();
        wr(16'h000F); chk("R2 first", 32'(snap), 32'h0);
        wr(16'h000F); chk("R2 pair", 32'(snap), 32'(P_DS));
        @(negedge clk); chk("R11 one cycle", 32'(outs()), 32'h0);
        wr(16'h000F); chk("R9 rearm no pulse", 32'(snap), 32'h0);
        wr(16'h0092); chk("R10 exit sealed", 32'(snap), 32'(P_CX));
        wr(16'h000F); chk("R9 cancelled", 32'(snap), 32'h0);
        wr(16'h000F); chk("R9 rearmed pair", 32'(snap), 32'(P_DS));
        wr(16'h000F);
        wr(16'h0012); chk("R6 reject", 32'(snap), 32'(P_REJ));
        wr(16'h000F); chk("R9 reject cancels", 32'(snap), 32'h0);
        wr(16'h000F); chk("R2 after rearm", 32'(snap), 32'(P_DS));
    endtask

    task automatic t_window();
        wr(16'h000F); ticks(WT - 1);
        wr(16'h000F); chk("R8 inside window", 32'(snap), 32'(P_DS));
        wr(16'h000F); ticks(WT);
        wr(16'h000F); chk("R8 expired", 32'(snap), 32'h0);
        wr(16'h000F); chk("R8 restart after expiry", 32'(snap), 32'(P_DS));
        wr(16'h2857); ticks(WT);
        wr(16'h29A3); chk("R8 pf expired", 32'(snap), 32'h0);
    endtask

    task automatic t_shutdown_sealed();
        wr(16'h0010); chk("R3 first", 32'(snap), 32'h0);
        wr(16'h0010); chk("R3 sealed", 32'(snap), 32'(P_SH));
    endtask

    task automatic t_pf();
        wr(16'h2857); chk("R4 arm", 32'(snap), 32'h0);
        wr(16'h29A3); chk("R4 fire", 32'(snap), 32'(P_PF));
        wr(16'h2857);
        wr(16'h0082); chk("R5 between", 32'(snap), 32'h0);
        wr(16'h29A3); chk("R5 cancelled", 32'(snap), 32'h0);
        wr(16'h29A3); chk("R5 alone", 32'(snap), 32'h0);
    endtask

    task automatic t_sealed_rejects();
        logic [15:0] lst [8] = '{16'h0012, 16'h001C, 16'h0020, 16'h0024,
                                 16'h0030, 16'h0090, 16'h29E7, 16'h7C40};
        for (int i = 0; i < 8; i++) begin
            wr(lst[i]);
            chk("R6 reject", 32'(snap), 32'(P_REJ));
            chk("R6 level", 32'(lvl_snap), 32'(L_SEALED));
        end
    endtask

    task automatic t_levels();
        req_full();   chk("R7 full from sealed ignored", 32'(lvl_snap), 32'(L_SEALED));
        req_unseal(); chk("R7 unseal", 32'(lvl_snap), 32'(L_UNSEAL));
        wr(16'h0012); chk("R10 reset", 32'(snap), 32'(P_RST));
        wr(16'h0090); chk("R10 cfg enter", 32'(snap), 32'(P_CE));
        wr(16'h0092); chk("R10 cfg exit unsealed", 32'(snap), 32'(P_CX));
        wr(16'h001E); chk("R6 accepted unsealed", 32'(snap), 32'h0);
        wr(16'h0010);
        wr(16'h0010); chk("R3 fast unsealed", 32'(snap), 32'(P_SH | P_FAST));
        req_unseal(); chk("R7 unseal ignored", 32'(lvl_snap), 32'(L_UNSEAL));
        req_full();   chk("R7 full", 32'(lvl_snap), 32'(L_FULL));
        wr(16'h0092); chk("R10 cfg exit full", 32'(snap), 32'(P_CX));
        wr(16'h0010);
        wr(16'h0010); chk("R3 fast full", 32'(snap), 32'(P_SH | P_FAST));
        wr(16'h0030); chk("R7 seal pulse", 32'(snap), 32'(P_SEAL));
        chk("R7 sealed", 32'(lvl_snap), 32'(L_SEALED));
        wr(16'h0010);
        wr(16'h0010); chk("R3 sealed again", 32'(snap), 32'(P_SH));
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deepsleep();
        t_window();
        t_shutdown_sealed();
        t_pf();
        t_sealed_rejects();
        t_levels();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule